// File: doc/BRIEF.md
# Non-Stalling Front-End Execution Unit

This unit is a short in-order pipeline that sits between instruction decode and the out-of-order dispatch stage. On every clock it takes a group of decoded integer ALU instructions. Each carries its destination tag, two source tags and any source values that decode already has. As the group moves through three stages, each instruction tries to execute. It uses the values it arrived with, or results forwarded from older instructions that have already executed and are still inside the unit.

The unit never stalls because of a missing operand, and it has no queue and no wakeup or select logic. An instruction that cannot execute simply travels on as a bubble, and younger groups keep flowing behind it. When an instruction reaches the last stage, it leaves in one of two forms. It is either marked done with its result, or it is marked for dispatch to the out-of-order backend, together with its operands as far as they were resolved. A downstream stall freezes the whole pipeline, and a flush empties it in one cycle.

Top module: `frontend_exec_unit`

## Requirements
- R1: While reset is asserted and right after it is released, no output slot is valid.
- R2: A group accepted on a clock edge while `stall` and `flush` are low appears at the outputs after two more accepting edges. Slot 0 is older than slot 1. An instruction that is not ready never holds back the groups behind it.
- R3: Opcodes are 0 add, 1 subtract (a-b), 2 AND, 3 OR, 4 XOR, 5 shift left, 6 logical shift right and 7 arithmetic shift right. The shift amount is the low log2(DATA_W) bits of the second operand.
- R4: An instruction whose two sources are ready on entry executes and leaves with `outDone` set and its result. Done is never reported unless both source ready bits are set.
- R5: A source that is not ready takes the result of an older, executed instruction in a later stage whose destination tag matches it. The instruction then executes in the same stage.
- R6: Inside a group, slot 1 can use the result of slot 0 one stage after slot 0 executes.
- R7: When several older instructions in the unit carry the matching destination tag, the value comes from the youngest of them.
- R8: If the youngest matching older instruction has not executed, the source stays not ready, even when an older executed value with the same tag is present. The instruction leaves with `outDispatch` set, `outDone` clear, and its unresolved ready bit clear.
- R9: A source that is not ready and has no matching producer in the unit stays not ready, and the instruction leaves with `outDispatch` set.
- R10: While `stall` is high and `flush` is low, every stage holds its contents and the input group is ignored.
- R11: `flush` invalidates every stage on the next edge and drops the input group. It takes priority over `stall`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| flush | input | 1 | Invalidate all stages and drop the input group |
| stall | input | 1 | Downstream stall, freezes all stages |
| inValid | input | GROUP_W | Per-slot valid of the incoming group |
| inOp | input | GROUP_W*3 | Per-slot opcode |
| inDst | input | GROUP_W*TAG_W | Per-slot destination tag |
| inSrcTag | input | GROUP_W*2*TAG_W | Source tags, slot w source k at index w*2+k |
| inSrcRdy | input | GROUP_W*2 | Source ready bits |
| inSrcVal | input | GROUP_W*2*DATA_W | Source values, valid where ready |
| outValid | output | GROUP_W | Per-slot valid leaving the last stage |
| outDone | output | GROUP_W | Instruction executed in this unit |
| outDispatch | output | GROUP_W | Instruction must go to the out-of-order backend |
| outOp | output | GROUP_W*3 | Opcode |
| outDst | output | GROUP_W*TAG_W | Destination tag |
| outSrcTag | output | GROUP_W*2*TAG_W | Source tags |
| outSrcRdy | output | GROUP_W*2 | Source ready bits after forwarding |
| outSrcVal | output | GROUP_W*2*DATA_W | Source values after forwarding |
| outResult | output | GROUP_W*DATA_W | Result, meaningful when done |

## Verification
Internal state errors reach the ports in a few distinct ways:
- A wrong forwarding choice, such as an older producer winning over a younger one, or a stale value used in place of a pending one, shows up as a wrong result or a done flag where a dispatch was due. It appears at the outputs at most two cycles later, when the affected group leaves the last stage.
- A stage that fails to hold under stall, or that keeps an entry through a flush, shows up as a valid slot in the wrong cycle or a duplicated group.
- A corrupted ready bit surfaces directly on `outSrcRdy`.

A behavioural age-ordered model is compared with every output slot on every cycle, so each of these errors is caught on the first cycle it becomes visible.

// File: rtl/fe_pkg.sv
package fe_pkg;
  localparam int TAG_W   = 5;
  localparam int DATA_W  = 32;
  localparam int OP_W    = 3;
  localparam int SRC_N   = 2;
  localparam int SHAMT_W = $clog2(DATA_W);

  typedef enum logic [OP_W-1:0] {
    OP_ADD = 3'd0,
    OP_SUB = 3'd1,
    OP_AND = 3'd2,
    OP_OR  = 3'd3,
    OP_XOR = 3'd4,
    OP_SLL = 3'd5,
    OP_SRL = 3'd6,
    OP_SRA = 3'd7
  } aluOp_e;

  // One instruction slot as it travels through the stages
  typedef struct packed {
    logic                              valid;
    aluOp_e                            op;
    logic [TAG_W-1:0]                  dst;
    logic [SRC_N-1:0][TAG_W-1:0]       srcTag;
    logic [SRC_N-1:0]                  srcRdy;
    logic [SRC_N-1:0][DATA_W-1:0]      srcVal;
    logic                              done;
    logic [DATA_W-1:0]                 result;
  } slot_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic advance;
    logic clear;
  } pipeCtl_t;
endpackage

// File: rtl/fe_alu.sv
module fe_alu
  import fe_pkg::*;
(
  input  aluOp_e              op,
  input  logic [DATA_W-1:0]   a,
  input  logic [DATA_W-1:0]   b,
  output logic [DATA_W-1:0]   y
);
  always_comb begin
    unique case (op)
      OP_ADD:  y = a + b;
      OP_SUB:  y = a - b;
      OP_AND:  y = a & b;
      OP_OR:   y = a | b;
      OP_XOR:  y = a ^ b;
      OP_SLL:  y = a << b[SHAMT_W-1:0];
      OP_SRL:  y = a >> b[SHAMT_W-1:0];
      OP_SRA:  y = DATA_W'($signed(a) >>> b[SHAMT_W-1:0]);
      default: y = '0;
    endcase
  end
endmodule

// File: rtl/fe_ctrl.sv
module fe_ctrl
  import fe_pkg::*;
(
  input  logic     flush,
  input  logic     stall,
  output pipeCtl_t ctl
);
  // Flush wins over stall; otherwise the whole pipeline moves together
  always_comb begin
    ctl.clear   = flush;
    ctl.advance = !flush && !stall;
  end
endmodule

// File: rtl/fe_datapath.sv
module fe_datapath
  import fe_pkg::*;
#(
  parameter int GROUP_W    = 2,
  parameter int NUM_STAGES = 3
) (
  input  logic     clk,
  input  logic     rstN,
  input  pipeCtl_t ctl,
  input  slot_t    inSlot  [GROUP_W],
  output slot_t    outSlot [GROUP_W]
);
  localparam int ENTRIES = GROUP_W * NUM_STAGES;

  slot_t stg [NUM_STAGES][GROUP_W];   // registered stage contents, higher index = older
  slot_t rsv [NUM_STAGES][GROUP_W];   // after operand forwarding
  slot_t nxt [NUM_STAGES][GROUP_W];   // after execution attempt
  logic [DATA_W-1:0] aluY [NUM_STAGES][GROUP_W];

  // Operand forwarding: scan older entries oldest-first so the youngest match is kept
  always_comb begin
    for (int s = 0; s < NUM_STAGES; s++) begin
      for (int w = 0; w < GROUP_W; w++) begin
        rsv[s][w] = stg[s][w];
        for (int k = 0; k < SRC_N; k++) begin
          logic              fwdHit;
          logic              fwdDone;
          logic [DATA_W-1:0] fwdVal;
          fwdHit  = 1'b0;
          fwdDone = 1'b0;
          fwdVal  = '0;
          for (int ps = NUM_STAGES - 1; ps >= 0; ps--) begin
            for (int pw = 0; pw < GROUP_W; pw++) begin
              if ((ps > s || (ps == s && pw < w)) && stg[ps][pw].valid &&
                  stg[ps][pw].dst == stg[s][w].srcTag[k]) begin
                fwdHit  = 1'b1;
                fwdDone = stg[ps][pw].done;
                fwdVal  = stg[ps][pw].result;
              end
            end
          end
          // A pending youngest producer blocks the source even if older values exist
          if (!stg[s][w].srcRdy[k] && fwdHit && fwdDone) begin
            rsv[s][w].srcRdy[k] = 1'b1;
            rsv[s][w].srcVal[k] = fwdVal;
          end
        end
      end
    end
  end

  for (genvar s = 0; s < NUM_STAGES; s++) begin : g_stage
    for (genvar w = 0; w < GROUP_W; w++) begin : g_slot
      fe_alu u_alu (
        .op (rsv[s][w].op),
        .a  (rsv[s][w].srcVal[0]),
        .b  (rsv[s][w].srcVal[1]),
        .y  (aluY[s][w])
      );
    end
  end

  // Execute whatever is ready; the rest passes on untouched as a bubble
  always_comb begin
    for (int s = 0; s < NUM_STAGES; s++) begin
      for (int w = 0; w < GROUP_W; w++) begin
        nxt[s][w] = rsv[s][w];
        if (rsv[s][w].valid && !rsv[s][w].done && (&rsv[s][w].srcRdy)) begin
          nxt[s][w].done   = 1'b1;
          nxt[s][w].result = aluY[s][w];
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int s = 0; s < NUM_STAGES; s++)
        for (int w = 0; w < GROUP_W; w++)
          stg[s][w] <= '0;
    end else if (ctl.clear) begin
      for (int s = 0; s < NUM_STAGES; s++)
        for (int w = 0; w < GROUP_W; w++)
          stg[s][w].valid <= 1'b0;
    end else if (ctl.advance) begin
      for (int w = 0; w < GROUP_W; w++) begin
        stg[0][w] <= inSlot[w];
        for (int s = 1; s < NUM_STAGES; s++)
          stg[s][w] <= nxt[s-1][w];
      end
    end
  end

  always_comb begin
    for (int w = 0; w < GROUP_W; w++)
      outSlot[w] = nxt[NUM_STAGES-1][w];
  end

  // Occupancy views for the checks below
  logic [ENTRIES-1:0] validVec;
  logic [ENTRIES-1:0] doneVec;
  always_comb begin
    for (int s = 0; s < NUM_STAGES; s++)
      for (int w = 0; w < GROUP_W; w++) begin
        validVec[s*GROUP_W + w] = stg[s][w].valid;
        doneVec[s*GROUP_W + w]  = stg[s][w].done;
      end
  end

  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rstN)
    ctl.clear |=> (validVec == '0));  // R11
  AST_STALL_FREEZE: assert property (@(posedge clk) disable iff (!rstN)
    (!ctl.advance && !ctl.clear) |=> ($stable(validVec) && $stable(doneVec)));  // R10
endmodule

// File: rtl/frontend_exec_unit.sv
module frontend_exec_unit
  import fe_pkg::*;
#(
  parameter int GROUP_W    = 2,
  parameter int NUM_STAGES = 3
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  logic                              flush,
  input  logic                              stall,
  input  logic [GROUP_W-1:0]                inValid,
  input  logic [GROUP_W*OP_W-1:0]           inOp,
  input  logic [GROUP_W*TAG_W-1:0]          inDst,
  input  logic [GROUP_W*SRC_N*TAG_W-1:0]    inSrcTag,
  input  logic [GROUP_W*SRC_N-1:0]          inSrcRdy,
  input  logic [GROUP_W*SRC_N*DATA_W-1:0]   inSrcVal,
  output logic [GROUP_W-1:0]                outValid,
  output logic [GROUP_W-1:0]                outDone,
  output logic [GROUP_W-1:0]                outDispatch,
  output logic [GROUP_W*OP_W-1:0]           outOp,
  output logic [GROUP_W*TAG_W-1:0]          outDst,
  output logic [GROUP_W*SRC_N*TAG_W-1:0]    outSrcTag,
  output logic [GROUP_W*SRC_N-1:0]          outSrcRdy,
  output logic [GROUP_W*SRC_N*DATA_W-1:0]   outSrcVal,
  output logic [GROUP_W*DATA_W-1:0]         outResult
);
  pipeCtl_t ctl;
  slot_t    inSlot  [GROUP_W];
  slot_t    outSlot [GROUP_W];

  always_comb begin
    for (int w = 0; w < GROUP_W; w++) begin
      inSlot[w]       = '0;
      inSlot[w].valid = inValid[w];
      inSlot[w].op    = aluOp_e'(inOp[w*OP_W +: OP_W]);
      inSlot[w].dst   = inDst[w*TAG_W +: TAG_W];
      for (int k = 0; k < SRC_N; k++) begin
        inSlot[w].srcTag[k] = inSrcTag[(w*SRC_N + k)*TAG_W +: TAG_W];
        inSlot[w].srcRdy[k] = inSrcRdy[w*SRC_N + k];
        inSlot[w].srcVal[k] = inSrcVal[(w*SRC_N + k)*DATA_W +: DATA_W];
      end
    end
  end

  fe_ctrl u_ctrl (
    .flush (flush),
    .stall (stall),
    .ctl   (ctl)
  );

  fe_datapath #(
    .GROUP_W    (GROUP_W),
    .NUM_STAGES (NUM_STAGES)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .ctl     (ctl),
    .inSlot  (inSlot),
    .outSlot (outSlot)
  );

  always_comb begin
    for (int w = 0; w < GROUP_W; w++) begin
      outValid[w]                     = outSlot[w].valid;
      outDone[w]                      = outSlot[w].valid && outSlot[w].done;
      outDispatch[w]                  = outSlot[w].valid && !outSlot[w].done;
      outOp[w*OP_W +: OP_W]           = outSlot[w].op;
      outDst[w*TAG_W +: TAG_W]        = outSlot[w].dst;
      outResult[w*DATA_W +: DATA_W]   = outSlot[w].result;
      for (int k = 0; k < SRC_N; k++) begin
        outSrcTag[(w*SRC_N + k)*TAG_W +: TAG_W]   = outSlot[w].srcTag[k];
        outSrcRdy[w*SRC_N + k]                    = outSlot[w].srcRdy[k];
        outSrcVal[(w*SRC_N + k)*DATA_W +: DATA_W] = outSlot[w].srcVal[k];
      end
    end
  end

  for (genvar w = 0; w < GROUP_W; w++) begin : g_chk
    AST_DONE_HAS_OPERANDS: assert property (@(posedge clk) disable iff (!rstN)
      outDone[w] |-> (&outSrcRdy[w*SRC_N +: SRC_N]));  // R4
    AST_ADD_RESULT: assert property (@(posedge clk) disable iff (!rstN)
      (outDone[w] && outOp[w*OP_W +: OP_W] == OP_ADD) |->
        (outResult[w*DATA_W +: DATA_W] ==
         outSrcVal[(w*SRC_N)*DATA_W +: DATA_W] + outSrcVal[(w*SRC_N + 1)*DATA_W +: DATA_W]));  // R3
  end
endmodule

// File: tb/frontend_exec_unit_tb.sv
module frontend_exec_unit_tb;
  localparam int GW = 2;
  localparam int NS = 3;
  localparam int NE = GW * NS;
  localparam int TW = fe_pkg::TAG_W;
  localparam int DW = fe_pkg::DATA_W;
  localparam int SH = $clog2(DW);

  logic clk = 1'b0;
  logic rstN, flush, stall;
  logic [GW-1:0]      inValid;
  logic [GW*3-1:0]    inOp;
  logic [GW*TW-1:0]   inDst;
  logic [GW*2*TW-1:0] inSrcTag;
  logic [GW*2-1:0]    inSrcRdy;
  logic [GW*2*DW-1:0] inSrcVal;
  logic [GW-1:0]      outValid, outDone, outDispatch;
  logic [GW*3-1:0]    outOp;
  logic [GW*TW-1:0]   outDst;
  logic [GW*2*TW-1:0] outSrcTag;
  logic [GW*2-1:0]    outSrcRdy;
  logic [GW*2*DW-1:0] outSrcVal;
  logic [GW*DW-1:0]   outResult;

  int    checks = 0;
  int    fails  = 0;
  bit    finished = 0;
  string curReq = "R1";

  always #5 clk = ~clk;

  frontend_exec_unit #(.GROUP_W(GW), .NUM_STAGES(NS)) u_dut (
    .clk(clk), .rstN(rstN), .flush(flush), .stall(stall),
    .inValid(inValid), .inOp(inOp), .inDst(inDst), .inSrcTag(inSrcTag),
    .inSrcRdy(inSrcRdy), .inSrcVal(inSrcVal),
    .outValid(outValid), .outDone(outDone), .outDispatch(outDispatch),
    .outOp(outOp), .outDst(outDst), .outSrcTag(outSrcTag), .outSrcRdy(outSrcRdy),
    .outSrcVal(outSrcVal), .outResult(outResult)
  );

  // Reference model: flat age-ordered list, index 0 = oldest instruction in the unit
  logic          mV [NE];  logic [2:0]    mOp [NE]; logic [TW-1:0] mD [NE];
  logic [TW-1:0] mT [NE][2]; logic        mRd [NE][2]; logic [DW-1:0] mVl [NE][2];
  logic          mDn [NE]; logic [DW-1:0] mRs [NE];
  logic          rV [NE];  logic [2:0]    rOp [NE]; logic [TW-1:0] rD [NE];
  logic [TW-1:0] rT [NE][2]; logic        rRd [NE][2]; logic [DW-1:0] rVl [NE][2];
  logic          rDn [NE]; logic [DW-1:0] rRs [NE];

  function automatic logic [DW-1:0] refAlu(logic [2:0] op, logic [DW-1:0] a, logic [DW-1:0] b);
    case (op)
      3'd0: return a + b;
      3'd1: return a - b;
      3'd2: return a & b;
      3'd3: return a | b;
      3'd4: return a ^ b;
      3'd5: return a << b[SH-1:0];
      3'd6: return a >> b[SH-1:0];
      default: return DW'($signed(a) >>> b[SH-1:0]);
    endcase
  endfunction

  task automatic computeR();
    for (int i = 0; i < NE; i++) begin
      rV[i] = mV[i]; rOp[i] = mOp[i]; rD[i] = mD[i]; rDn[i] = mDn[i]; rRs[i] = mRs[i];
      for (int k = 0; k < 2; k++) begin
        bit found = 0; bit fDone = 0; logic [DW-1:0] fVal = '0;
        rT[i][k] = mT[i][k]; rRd[i][k] = mRd[i][k]; rVl[i][k] = mVl[i][k];
        for (int j = 0; j < i; j++)
          if (mV[j] && mD[j] == mT[i][k]) begin found = 1; fDone = mDn[j]; fVal = mRs[j]; end
        if (!mRd[i][k] && found && fDone) begin rRd[i][k] = 1'b1; rVl[i][k] = fVal; end
      end
      if (rV[i] && !rDn[i] && rRd[i][0] && rRd[i][1]) begin
        rDn[i] = 1'b1; rRs[i] = refAlu(rOp[i], rVl[i][0], rVl[i][1]);
      end
    end
  endtask

  task automatic modelStep();
    if (flush) begin
      for (int i = 0; i < NE; i++) mV[i] = 1'b0;
    end else if (!stall) begin
      computeR();
      for (int i = 0; i < NE - GW; i++) begin
        mV[i] = rV[i+GW]; mOp[i] = rOp[i+GW]; mD[i] = rD[i+GW]; mDn[i] = rDn[i+GW]; mRs[i] = rRs[i+GW];
        for (int k = 0; k < 2; k++) begin
          mT[i][k] = rT[i+GW][k]; mRd[i][k] = rRd[i+GW][k]; mVl[i][k] = rVl[i+GW][k];
        end
      end
      for (int w = 0; w < GW; w++) begin
        int i = NE - GW + w;
        mV[i] = inValid[w]; mOp[i] = inOp[w*3 +: 3]; mD[i] = inDst[w*TW +: TW];
        mDn[i] = 1'b0; mRs[i] = '0;
        for (int k = 0; k < 2; k++) begin
          mT[i][k] = inSrcTag[(w*2+k)*TW +: TW]; mRd[i][k] = inSrcRdy[w*2+k];
          mVl[i][k] = inSrcVal[(w*2+k)*DW +: DW];
        end
      end
    end
    computeR();
  endtask

  task automatic compareOut();
    for (int w = 0; w < GW; w++) begin
      logic [255:0] expV = '0;
      logic [255:0] actV = '0;
      if (rV[w])
        expV = {1'b1, rDn[w], !rDn[w], rOp[w], rD[w], rT[w][1], rT[w][0], rRd[w][1], rRd[w][0],
                rRd[w][1] ? rVl[w][1] : DW'(0), rRd[w][0] ? rVl[w][0] : DW'(0),
                rDn[w] ? rRs[w] : DW'(0)};
      if (outValid[w])
        actV = {1'b1, outDone[w], outDispatch[w], outOp[w*3 +: 3], outDst[w*TW +: TW],
                outSrcTag[(w*2+1)*TW +: TW], outSrcTag[(w*2)*TW +: TW], outSrcRdy[w*2+1], outSrcRdy[w*2],
                rRd[w][1] ? outSrcVal[(w*2+1)*DW +: DW] : DW'(0),
                rRd[w][0] ? outSrcVal[(w*2)*DW +: DW] : DW'(0),
                rDn[w] ? outResult[w*DW +: DW] : DW'(0)};
      checks++;
      if (actV !== expV) begin
        fails++;
        $display("FAIL %s model compare slot %0d at %0t: actual=%h expected=%h", curReq, w, $time, actV, expV);
      end
    end
  endtask

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s at %0t: actual=%h expected=%h", req, $time, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    modelStep();
    compareOut();
  endtask

  task automatic idle();
    inValid = '0; inOp = '0; inDst = '0; inSrcTag = '0; inSrcRdy = '0; inSrcVal = '0;
  endtask

  task automatic put(int w, int op, int dst, int t0, bit r0, logic [DW-1:0] v0,
                     int t1, bit r1, logic [DW-1:0] v1);
    inValid[w] = 1'b1;
    inOp[w*3 +: 3] = 3'(op);
    inDst[w*TW +: TW] = TW'(dst);
    inSrcTag[(w*2)*TW +: TW] = TW'(t0);  inSrcRdy[w*2] = r0;   inSrcVal[(w*2)*DW +: DW] = v0;
    inSrcTag[(w*2+1)*TW +: TW] = TW'(t1); inSrcRdy[w*2+1] = r1; inSrcVal[(w*2+1)*DW +: DW] = v1;
  endtask

  task automatic finishRun();
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: actual=hung expected=finished");
      finishRun();
    end
  end

  initial begin
    rstN = 1'b0; flush = 1'b0; stall = 1'b0; idle();
    for (int i = 0; i < NE; i++) begin
      mV[i] = 0; mOp[i] = 0; mD[i] = 0; mDn[i] = 0; mRs[i] = 0;
      for (int k = 0; k < 2; k++) begin mT[i][k] = 0; mRd[i][k] = 0; mVl[i][k] = 0; end
    end
    computeR();
    repeat (3) @(negedge clk);
    chk("R1", 64'(outValid), 64'd0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1", 64'(outValid), 64'd0);

    // R4 / R6: ready add, then slot 1 using slot 0's result
    curReq = "R6";
    idle(); put(0, 0, 1, 0, 1, 3, 0, 1, 4); put(1, 0, 2, 1, 0, 0, 0, 1, 1);
    tick(); idle(); tick(); tick();
    chk("R4", 64'(outDone), 64'd3);
    chk("R4", 64'(outResult[0 +: DW]), 64'd7);
    chk("R6", 64'(outResult[DW +: DW]), 64'd8);

    // R3: arithmetic shift right and subtract
    curReq = "R3";
    idle(); put(0, 7, 3, 0, 1, 32'h8000_0000, 0, 1, 4); put(1, 1, 4, 0, 1, 5, 0, 1, 7);
    tick(); idle(); tick(); tick();
    chk("R3", 64'(outResult[0 +: DW]), 64'hF800_0000);
    chk("R3", 64'(outResult[DW +: DW]), 64'hFFFF_FFFE);

    // R5 / R7 / R8 / R9: back-to-back dependent groups
    curReq = "R8";
    idle(); put(0, 0, 10, 0, 1, 1, 0, 1, 1); put(1, 0, 12, 0, 1, 100, 0, 1, 0); tick();
    idle(); put(0, 0, 10, 30, 0, 0, 0, 1, 1); put(1, 0, 12, 0, 1, 5, 0, 1, 5); tick();
    idle(); put(0, 0, 20, 10, 0, 0, 0, 1, 0); put(1, 0, 21, 12, 0, 0, 0, 1, 1); tick();
    chk("R4", 64'(outDone), 64'd3);
    chk("R4", 64'(outResult[DW +: DW]), 64'd100);
    idle(); put(0, 0, 5, 31, 0, 0, 0, 1, 0); tick();
    chk("R9", 64'(outDispatch), 64'd1);
    chk("R2", 64'(outResult[DW +: DW]), 64'd10);
    idle(); tick();
    chk("R8", 64'(outDispatch[0]), 64'd1);
    chk("R8", 64'(outSrcRdy[1:0]), 64'b10);
    chk("R5", 64'(outDone[1]), 64'd1);
    chk("R7", 64'(outResult[DW +: DW]), 64'd11);
    tick();
    chk("R9", 64'(outDispatch), 64'd1);

    // R10: stall holds the pipe and ignores input
    curReq = "R10";
    idle(); put(0, 0, 1, 0, 1, 2, 0, 1, 2); tick();
    stall = 1'b1; idle(); put(0, 0, 2, 0, 1, 9, 0, 1, 9);
    tick(); tick(); tick();
    chk("R10", 64'(outValid), 64'd0);
    stall = 1'b0; idle(); tick(); tick();
    chk("R10", 64'(outValid), 64'd1);
    chk("R10", 64'(outResult[0 +: DW]), 64'd4);
    tick();
    chk("R10", 64'(outValid), 64'd0);

    // R11: flush with stall also high
    curReq = "R11";
    idle(); put(0, 0, 3, 0, 1, 1, 0, 1, 1); tick(); tick();
    flush = 1'b1; stall = 1'b1; tick();
    chk("R11", 64'(outValid), 64'd0);
    flush = 1'b0; stall = 1'b0; idle(); tick(); tick();
    chk("R11", 64'(outValid), 64'd0);

    // R2: mixed random stream with occasional stall and flush
    curReq = "R2";
    for (int c = 0; c < 600; c++) begin
      idle();
      for (int w = 0; w < GW; w++)
        if ($urandom_range(0, 99) < 85)
          put(w, $urandom_range(0, 7), $urandom_range(0, 7),
              $urandom_range(0, 7), 1'($urandom_range(0, 1)), $urandom,
              $urandom_range(0, 7), 1'($urandom_range(0, 1)), $urandom);
      stall = ($urandom_range(0, 99) < 10);
      flush = ($urandom_range(0, 99) < 2);
      tick();
    end
    flush = 1'b0; stall = 1'b0; idle();
    tick(); tick(); tick();
    finishRun();
  end
endmodule